// File: doc/BRIEF.md
# Code-Selected Byte Readback Port

This block is the host-side read path for a set of internal multi-byte results. The host reaches it through an 8-bit byte bus with a 3-bit address and active-low write and read strobes, all sampled by the block clock. A write to one reserved address stores a 3-bit source code that picks a group of results: I/Q samples, magnitude and phase, frequency, or the 24-bit input level. The bus address then picks one byte inside that group. The block drives the byte on the read data port, and a separate enable tells the pad ring when to turn on the tri-state driver.

Multi-byte groups are read one byte at a time, so the block takes a snapshot of the whole group when byte 0 is read. Later bytes come from that snapshot, which keeps a multi-byte read coherent while the producers keep updating. One address bypasses the source code and returns the live status byte, so status can be polled without first writing a code.

Top module: `host_readback_port`

## Requirements
- R1: A write strobe rising edge (host_wr_n seen low, then high on the next sample) with host_addr = 5 stores host_wdata[2:0] as the source code. Writes to any other address leave the code unchanged. The code is 000 after reset.
- R2: Code 000 (I/Q) maps address 0 to I[7:0], 1 to I[15:8], 2 to Q[7:0] and 3 to Q[15:8].
- R3: Code 001 maps address 0 to magnitude[7:0], 1 to magnitude[15:8], 2 to phase[7:0] and 3 to phase[15:8].
- R4: Code 010 maps address 0 to frequency[7:0] and 1 to frequency[15:8]. Addresses 2 and 3 return 0x00.
- R5: Code 100 maps addresses 0, 1 and 2 to level bits 7:0, 15:8 and 23:16. Address 3 returns 0x00.
- R6: Address 7 returns the live status byte whatever the stored code.
- R7: Codes 011, 101, 110 and 111 return 0x00 at addresses 0 to 6. Addresses 4, 5 and 6 return 0x00 under every code.
- R8: The returned byte is captured at the first clock edge that samples host_rd_n low after it was sampled high. It then holds until the next such falling edge, even if sources, address or code change.
- R9: host_rdata_oe is high exactly while host_rd_n is low and was also low at the previous clock edge. It goes low as soon as host_rd_n goes high, and it is low after reset.
- R10: A read at address 0 under a valid code snapshots the whole group. Reads at addresses 1 to 3 return bytes of the most recent snapshot, not the live value.
- R11: After reset, host_rdata is 0x00 and the snapshot is all zero, so an upper-byte read before any address-0 read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; host strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Host byte address |
| host_wdata | input | 8 | Host write data; bits 2:0 carry the source code |
| host_wr_n | input | 1 | Active-low write strobe |
| host_rd_n | input | 1 | Active-low read strobe |
| iq_i | input | 16 | In-phase sample |
| iq_q | input | 16 | Quadrature sample |
| mag | input | 16 | Magnitude |
| phase | input | 16 | Phase |
| freq | input | 16 | Frequency word |
| level | input | 24 | Input level value |
| status | input | 8 | Status byte |
| host_rdata | output | 8 | Returned byte |
| host_rdata_oe | output | 1 | Enable for the external tri-state bus driver |

## Verification
A wrong stored code appears at the next read as a byte from the wrong group or as 0x00, and nowhere else. For that reason, every group read follows a code write that is checked by its first byte. A stale or wrongly loaded snapshot is invisible until an upper-byte read. The bench therefore changes the live sources between the byte-0 read and the later reads, so a missing or misplaced snapshot shows one read later. A wrong strobe-history bit shows within one clock as an enable pulse that comes early or is missing, and the reference model compares that enable on every cycle.

// File: rtl/rbk_pkg.sv
`timescale 1ns/1ps
package rbk_pkg;

  localparam int RBK_CODE_W = 3;

  // Source group selectors; values are fixed by the host-visible map.
  typedef enum logic [RBK_CODE_W-1:0] {
    SRC_IQ     = 3'b000,
    SRC_MAGPH  = 3'b001,
    SRC_FREQ   = 3'b010,
    SRC_SPARE  = 3'b011,
    SRC_LEVEL  = 3'b100
  } src_code_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rbk_strobe_edge.sv
`timescale 1ns/1ps
// Samples an active-low host strobe and reports its edges.
module rbk_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall,
  output logic rise,
  output logic prev_q
);

  logic prev_d;

  always_comb begin
    prev_d = strobe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  assign fall = prev_q & ~strobe_n;
  assign rise = ~prev_q & strobe_n;

endmodule

// File: rtl/rbk_code_reg.sv
`timescale 1ns/1ps
// Holds the source code written by the host at the code address.
module rbk_code_reg #(
  parameter int ADDR_W    = 3,
  parameter int CODE_W    = 3,
  parameter int CODE_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rise,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);

  logic              code_en;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_en = wr_rise && (addr == ADDR_W'(CODE_ADDR));
    code_d  = code_en ? code_in : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

endmodule

// File: rtl/rbk_group_mux.sv
`timescale 1ns/1ps
// Packs the group chosen by the source code into one zero-extended word.
module rbk_group_mux
  import rbk_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int LEVEL_W = 24,
  parameter int SNAP_W  = 32
) (
  input  logic [RBK_CODE_W-1:0] code,
  input  logic [WORD_W-1:0]     iq_i,
  input  logic [WORD_W-1:0]     iq_q,
  input  logic [WORD_W-1:0]     mag,
  input  logic [WORD_W-1:0]     phase,
  input  logic [WORD_W-1:0]     freq,
  input  logic [LEVEL_W-1:0]    level,
  output logic [SNAP_W-1:0]     group_word,
  output logic                  group_valid
);

  always_comb begin
    group_word  = '0;
    group_valid = 1'b1;
    case (src_code_e'(code))
      SRC_IQ:    group_word = SNAP_W'({iq_q, iq_i});
      SRC_MAGPH: group_word = SNAP_W'({phase, mag});
      SRC_FREQ:  group_word = SNAP_W'(freq);
      SRC_LEVEL: group_word = SNAP_W'(level);
      default:   group_valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/rbk_byte_path.sv
`timescale 1ns/1ps
// Snapshot register, byte selection and the returned-byte register.
module rbk_byte_path #(
  parameter int BUS_W       = 8,
  parameter int ADDR_W      = 3,
  parameter int SNAP_W      = 32,
  parameter int STATUS_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fall,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SNAP_W-1:0] group_word,
  input  logic              group_valid,
  input  logic [BUS_W-1:0]  status,
  output logic [BUS_W-1:0]  rdata_q,
  output logic [SNAP_W-1:0] snap_q
);

  localparam int SNAP_BYTES = SNAP_W / BUS_W;

  logic [BUS_W-1:0]  snap_byte [SNAP_BYTES];
  logic [BUS_W-1:0]  sel_byte;
  logic              snap_en;
  logic [SNAP_W-1:0] snap_d;
  logic [BUS_W-1:0]  rdata_d;

  for (genvar k = 0; k < SNAP_BYTES; k++) begin : g_bytes
    assign snap_byte[k] = snap_q[k*BUS_W +: BUS_W];
  end

  // Byte chosen by address; the low byte bypasses the snapshot.
  always_comb begin
    sel_byte = '0;
    if (addr == ADDR_W'(STATUS_ADDR)) begin
      sel_byte = status;
    end else if (group_valid) begin
      if (addr == '0) begin
        sel_byte = group_word[BUS_W-1:0];
      end else begin
        for (int k = 1; k < SNAP_BYTES; k++) begin
          if (addr == ADDR_W'(k)) sel_byte = snap_byte[k];
        end
      end
    end
  end

  always_comb begin
    snap_en = rd_fall && group_valid && (addr == '0);
    snap_d  = snap_en ? group_word : snap_q;
    rdata_d = rd_fall ? sel_byte : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      snap_q  <= snap_d;
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/host_readback_port.sv
`timescale 1ns/1ps
module host_readback_port
  import rbk_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int ADDR_W      = 3,
  parameter int WORD_W      = 16,
  parameter int LEVEL_W     = 24,
  parameter int CODE_ADDR   = 5,
  parameter int STATUS_ADDR = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [BUS_W-1:0]   host_wdata,
  input  logic               host_wr_n,
  input  logic               host_rd_n,
  input  logic [WORD_W-1:0]  iq_i,
  input  logic [WORD_W-1:0]  iq_q,
  input  logic [WORD_W-1:0]  mag,
  input  logic [WORD_W-1:0]  phase,
  input  logic [WORD_W-1:0]  freq,
  input  logic [LEVEL_W-1:0] level,
  input  logic [BUS_W-1:0]   status,
  output logic [BUS_W-1:0]   host_rdata,
  output logic               host_rdata_oe
);

  localparam int SNAP_W = max2(2 * WORD_W, LEVEL_W);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic                  wr_fall_unused, wr_rise, wr_prev_unused;
  logic                  rd_fall, rd_rise_unused, rd_prev;
  logic [RBK_CODE_W-1:0] code_q;
  logic [SNAP_W-1:0]     group_word;
  logic                  group_valid;
  logic [SNAP_W-1:0]     snap_q;
  logic                  unused_wdata;

  assign unused_wdata = ^host_wdata[BUS_W-1:RBK_CODE_W];

  rbk_strobe_edge u_wr_edge (
    .clk(clk), .rst_n(srst_n), .strobe_n(host_wr_n),
    .fall(wr_fall_unused), .rise(wr_rise), .prev_q(wr_prev_unused)
  );

  rbk_strobe_edge u_rd_edge (
    .clk(clk), .rst_n(srst_n), .strobe_n(host_rd_n),
    .fall(rd_fall), .rise(rd_rise_unused), .prev_q(rd_prev)
  );

  rbk_code_reg #(
    .ADDR_W(ADDR_W), .CODE_W(RBK_CODE_W), .CODE_ADDR(CODE_ADDR)
  ) u_code (
    .clk(clk), .rst_n(srst_n), .wr_rise(wr_rise), .addr(host_addr),
    .code_in(host_wdata[RBK_CODE_W-1:0]), .code_q(code_q)
  );

  rbk_group_mux #(
    .WORD_W(WORD_W), .LEVEL_W(LEVEL_W), .SNAP_W(SNAP_W)
  ) u_group (
    .code(code_q), .iq_i(iq_i), .iq_q(iq_q), .mag(mag), .phase(phase),
    .freq(freq), .level(level), .group_word(group_word),
    .group_valid(group_valid)
  );

  rbk_byte_path #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .SNAP_W(SNAP_W),
    .STATUS_ADDR(STATUS_ADDR)
  ) u_bytes (
    .clk(clk), .rst_n(srst_n), .rd_fall(rd_fall), .addr(host_addr),
    .group_word(group_word), .group_valid(group_valid), .status(status),
    .rdata_q(host_rdata), .snap_q(snap_q)
  );

  // Driver enable: only once the byte for this strobe has been captured.
  assign host_rdata_oe = ~host_rd_n & ~rd_prev;

endmodule

// Assertion checker, attached below.
module host_readback_port_chk #(
  parameter int BUS_W       = 8,
  parameter int ADDR_W      = 3,
  parameter int LEVEL_W     = 24,
  parameter int SNAP_W      = 32,
  parameter int CODE_ADDR   = 5,
  parameter int STATUS_ADDR = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic [BUS_W-1:0]   wdata,
  input logic               rd_n,
  input logic [LEVEL_W-1:0] level,
  input logic [BUS_W-1:0]   status,
  input logic [BUS_W-1:0]   rdata,
  input logic               oe,
  input logic [2:0]         code,
  input logic               wr_rise,
  input logic               rd_fall,
  input logic [SNAP_W-1:0]  snap
);

  // R1
  code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && addr == ADDR_W'(CODE_ADDR)) |=> (code == $past(wdata[2:0])));

  // R1
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_rise && addr == ADDR_W'(CODE_ADDR)) |=> $stable(code));

  // R6
  status_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && addr == ADDR_W'(STATUS_ADDR)) |=> (rdata == $past(status)));

  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && addr >= ADDR_W'(4) && addr <= ADDR_W'(6)) |=> (rdata == '0));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fall |=> $stable(rdata));

  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !oe);

  // R10
  level_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && addr == '0 && code == 3'b100) |=>
    (snap[LEVEL_W-1:0] == $past(level)));

endmodule

bind host_readback_port host_readback_port_chk #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W), .SNAP_W(SNAP_W),
  .CODE_ADDR(CODE_ADDR), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk(clk), .rst_n(srst_n), .addr(host_addr), .wdata(host_wdata),
  .rd_n(host_rd_n), .level(level), .status(status), .rdata(host_rdata),
  .oe(host_rdata_oe), .code(code_q), .wr_rise(wr_rise), .rd_fall(rd_fall),
  .snap(snap_q)
);

// File: tb/host_readback_port_bench.sv
`timescale 1ns/1ps
module host_readback_port_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [15:0] iq_i = '0, iq_q = '0, mag = '0, phase = '0, freq = '0;
  logic [23:0] level = '0;
  logic [7:0]  status = '0;
  logic [7:0]  rdata;
  logic        oe;

  int checks = 0;
  int errors = 0;
  bit timed_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_readback_port u_host_readback_port (
    .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_wdata(wdata),
    .host_wr_n(wr_n), .host_rd_n(rd_n), .iq_i(iq_i), .iq_q(iq_q),
    .mag(mag), .phase(phase), .freq(freq), .level(level), .status(status),
    .host_rdata(rdata), .host_rdata_oe(oe)
  );

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model.
  logic        m_wrp, m_rdp;
  logic [2:0]  m_code;
  logic [31:0] m_snap;
  logic [7:0]  m_rdata;

  function automatic bit grp(input logic [2:0] c, output logic [31:0] g);
    g = 32'h0;
    case (c)
      3'd0: g = {iq_q, iq_i};
      3'd1: g = {phase, mag};
      3'd2: g = {16'h0, freq};
      3'd4: g = {8'h0, level};
      default: return 1'b0;
    endcase
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wrp <= 1'b1; m_rdp <= 1'b1; m_code <= '0;
      m_snap <= '0; m_rdata <= '0;
    end else begin
      logic [31:0] g;
      bit gv;
      m_wrp <= wr_n;
      m_rdp <= rd_n;
      if (!m_wrp && wr_n && addr == 3'd5) m_code <= wdata[2:0];
      if (m_rdp && !rd_n) begin
        gv = grp(m_code, g);
        if (addr == 3'd7) m_rdata <= status;
        else if (!gv) m_rdata <= 8'h00;
        else if (addr == 3'd0) begin
          m_rdata <= g[7:0];
          m_snap  <= g;
        end else if (addr < 3'd4) m_rdata <= m_snap[addr*8 +: 8];
        else m_rdata <= 8'h00;
      end
    end
  end

  // Per-clock comparison against the model.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      check("R8 rdata vs model", rdata, m_rdata);
      check("R9 oe vs model", {7'h0, oe}, {7'h0, (!rd_n && !m_rdp)});
    end
  end

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_read(input logic [2:0] a, input logic [7:0] exp,
                           input string tag);
    @(negedge clk); addr = a; rd_n = 1'b0;
    @(posedge clk); #(CLK_PERIOD/4);
    check(tag, rdata, exp);
    check({tag, " oe"}, {7'h0, oe}, 8'h01);
    @(negedge clk); rd_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R9 oe low after release", {7'h0, oe}, 8'h00);
    @(negedge clk);
  endtask

  task automatic run_tests;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 rdata after reset", rdata, 8'h00);
    check("R9 oe after reset", {7'h0, oe}, 8'h00);
    iq_i = 16'h1234; iq_q = 16'h5678;
    host_read(3'd1, 8'h00, "R11 empty snapshot");
    host_read(3'd0, 8'h34, "R2 I lsb");
    host_read(3'd1, 8'h12, "R2 I msb");
    host_read(3'd2, 8'h78, "R2 Q lsb");
    host_read(3'd3, 8'h56, "R2 Q msb");
    host_write(3'd3, 8'h01);
    host_read(3'd0, 8'h34, "R1 other address ignored");
    mag = 16'hABCD; phase = 16'h9F01;
    host_write(3'd5, 8'hF9);
    host_read(3'd0, 8'hCD, "R3 mag lsb");
    host_read(3'd1, 8'hAB, "R3 mag msb");
    host_read(3'd2, 8'h01, "R3 phase lsb");
    host_read(3'd3, 8'h9F, "R3 phase msb");
    freq = 16'hBEEF;
    host_write(3'd5, 8'h02);
    host_read(3'd0, 8'hEF, "R4 freq lsb");
    host_read(3'd1, 8'hBE, "R4 freq msb");
    host_read(3'd2, 8'h00, "R4 addr2 zero");
    host_read(3'd3, 8'h00, "R4 addr3 zero");
    level = 24'h321AF5; status = 8'hA5;
    host_write(3'd5, 8'h04);
    host_read(3'd0, 8'hF5, "R5 level b0");
    level = 24'h0B0C0D;
    host_read(3'd1, 8'h1A, "R10 snapshot b1");
    host_read(3'd2, 8'h32, "R10 snapshot b2");
    host_read(3'd3, 8'h00, "R5 addr3 zero");
    host_read(3'd0, 8'h0D, "R10 new snapshot b0");
    host_read(3'd1, 8'h0C, "R10 new snapshot b1");
    host_read(3'd2, 8'h0B, "R5 level b2");
    host_read(3'd7, 8'hA5, "R6 status code4");
    host_write(3'd5, 8'h03);
    host_read(3'd7, 8'hA5, "R6 status code3");
    host_read(3'd0, 8'h00, "R7 code3 zero");
    host_write(3'd5, 8'h05);
    host_read(3'd1, 8'h00, "R7 code5 zero");
    host_write(3'd5, 8'h06);
    host_read(3'd0, 8'h00, "R7 code6 zero");
    host_write(3'd5, 8'h07);
    host_read(3'd2, 8'h00, "R7 code7 zero");
    host_write(3'd5, 8'h00);
    host_read(3'd4, 8'h00, "R7 addr4 zero");
    host_read(3'd5, 8'h00, "R7 addr5 zero");
    host_read(3'd6, 8'h00, "R7 addr6 zero");
    // R8: hold while the strobe stays low.
    @(negedge clk); addr = 3'd7; rd_n = 1'b0;
    @(negedge clk); status = 8'h3C; addr = 3'd0;
    repeat (2) @(negedge clk);
    check("R8 held byte", rdata, 8'hA5);
    rd_n = 1'b1;
    @(negedge clk);
    check("R8 held after release", rdata, 8'hA5);
    host_read(3'd7, 8'h3C, "R6 live status");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule